// File: doc/BRIEF.md
# Link Power-Status Interface Reset Controller

This block sits on the physical-layer side of the PHY-to-link interface and watches the link's power-status input. While that input stays asserted, the internal control (2-bit) and data (8-bit) values pass straight to the interface pins. The controller only treats the link as powered down after the input has been continuously low for a programmable number of clock cycles. It then drives every line to zero for a short wind-down period and releases the lines to high impedance. The interface stays in that reset state until the link asserts power-status again.

Before the interface leaves reset, a minimum restore interval must run. If power-status returns too early, the controller records a sticky violation and keeps the interface in reset until the interval has completed. Once power-status is accepted, an initialisation phase drives zeros for a set number of cycles, and normal traffic then resumes.

The sequence applies only in the directly coupled mode, selected by the isolation strap being low. With the strap high, loss of power-status never takes the interface out of normal operation. All thresholds are parameters counted in clock cycles. The power-status input passes through a two-flop synchroniser before it is used.

Top module: `lps_reset_ctrl`

## Requirements
- R1: While and after rst_ni is low, before power-status has been accepted: ctl_oe_o=0, data_oe_o=0, ctl_o=0, data_o=0, if_reset_o=1 and restore_viol_o=0. The restore interval counts as already met at this point.
- R2: In normal operation, ctl_oe_o=1 and data_oe_o=1. ctl_o equals ctl_val_i when ctl_vld_i=1 and is 0 otherwise. data_o follows data_val_i and data_vld_i in the same way. Both paths are combinational and if_reset_o=0.
- R3: If lps_i is sampled low on fewer than LPS_RESET_CYC consecutive clock edges, normal operation continues unchanged.
- R4: Let lps_i be first sampled low at edge P0 and stay low. Normal operation holds through the state after edge P(LPS_RESET_CYC). Then, for WIND_CYC cycles, both enables stay 1 and both outputs are 0, whatever the valid inputs are.
- R5: After the wind-down, both enables are 0, both outputs are 0 and if_reset_o=1. The block stays in this state while lps_i stays low.
- R6: The synchronised power-status input reaches the controller two edges after it is sampled at the pin. If it arrives high before the reset state has lasted RESTORE_CYC cycles, restore_viol_o becomes 1 and the interface stays in reset. Initialisation starts at the first edge at which the interval is complete and power-status is still high.
- R7: Suppose the restore interval is already met and lps_i is first sampled high at edge Q0. The block stays in reset through the state after Q1. From Q2 it drives zeros with both enables at 1 and if_reset_o=0 for INIT_CYC cycles, and then it returns to normal operation.
- R8: While iso_i=1, loss of power-status never takes the block out of normal operation.
- R9: restore_viol_o stays 1 once set, and only rst_ni clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lps_i | input | 1 | Link power-status, asynchronous |
| iso_i | input | 1 | Isolation strap; 0 selects the directly coupled mode |
| ctl_val_i | input | 2 | Internal control value |
| ctl_vld_i | input | 1 | Control value valid |
| data_val_i | input | 8 | Internal data value |
| data_vld_i | input | 1 | Data value valid |
| ctl_o | output | 2 | Driven control line value |
| ctl_oe_o | output | 1 | Control line output enable |
| data_o | output | 8 | Driven data line value |
| data_oe_o | output | 1 | Data line output enable |
| if_reset_o | output | 1 | Interface is in the reset state |
| restore_viol_o | output | 1 | Sticky flag: power-status returned too early |

## Verification
The bench sweeps the dropout length from one cycle up to exactly one below the threshold. A controller that counted an edge too few would reset the interface on the longest glitch. A controller that failed to clear its counter would add up separate dropouts. A held dropout is tracked edge by edge to confirm that zeros are driven, while traffic is still valid, before the enables fall; a design that released at once would float nonzero lines. An early re-assertion must raise the sticky flag and hold reset for exactly the remaining interval, and the bench counts the exact initialisation length. Isolated mode is checked for ignoring a long dropout.

// File: rtl/lps_rc_pkg.sv
package lps_rc_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_WIND   = 2'd1,
    ST_RESET  = 2'd2,
    ST_INIT   = 2'd3
  } rc_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/lps_sync.sv
module lps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/lps_inact_cnt.sv
module lps_inact_cnt #(
  parameter int LIMIT = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lps_s_i,
  output logic timeout_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // any active sample restarts the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (lps_s_i)      cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign timeout_o = !lps_s_i && (cnt_q == LAST);
endmodule

// File: rtl/lps_rc_fsm.sv
module lps_rc_fsm
  import lps_rc_pkg::*;
#(
  parameter int RESTORE_CYC = 64,
  parameter int INIT_CYC    = 8,
  parameter int WIND_CYC    = 1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lps_s_i,
  input  logic      iso_i,
  input  logic      timeout_i,
  output rc_state_e st_o,
  output logic      restore_met_o,
  output logic      drive_o,
  output logic      pass_o,
  output logic      if_reset_o,
  output logic      viol_o
);
  localparam int MAXC = max3(RESTORE_CYC, INIT_CYC, WIND_CYC);
  localparam int PW   = $clog2(MAXC + 1);
  localparam logic [PW-1:0] RST_END  = PW'(RESTORE_CYC);
  localparam logic [PW-1:0] INIT_END = PW'(INIT_CYC - 1);
  localparam logic [PW-1:0] WIND_END = PW'(WIND_CYC - 1);

  rc_state_e     st_q, st_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic          viol_q, viol_d;
  logic          met;

  assign met = (st_q == ST_RESET) && (cnt_q == RST_END);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    viol_d = viol_q;
    unique case (st_q)
      ST_NORMAL: begin
        if (timeout_i && !iso_i) begin
          st_d  = ST_WIND;
          cnt_d = '0;
        end
      end
      ST_WIND: begin
        if (cnt_q == WIND_END) begin
          st_d  = ST_RESET;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RESET: begin
        if (lps_s_i && met) begin
          st_d  = ST_INIT;
          cnt_d = '0;
        end else begin
          if (lps_s_i) viol_d = 1'b1;
          if (!met)    cnt_d  = cnt_q + 1'b1;
        end
      end
      ST_INIT: begin
        if (timeout_i) begin
          st_d  = ST_WIND;
          cnt_d = '0;
        end else if (cnt_q == INIT_END) begin
          st_d  = ST_NORMAL;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_RESET;
    endcase
  end

  // power-up lands in reset with the restore interval already satisfied
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RESET;
      cnt_q  <= RST_END;
      viol_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      viol_q <= viol_d;
    end
  end

  assign st_o          = st_q;
  assign restore_met_o = met;
  assign drive_o       = (st_q != ST_RESET);
  assign pass_o        = (st_q == ST_NORMAL);
  assign if_reset_o    = (st_q == ST_RESET);
  assign viol_o        = viol_q;
endmodule

// File: rtl/lps_lane_drv.sv
module lps_lane_drv #(
  parameter int W = 8
) (
  input  logic         drive_i,
  input  logic         pass_i,
  input  logic         vld_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] out_o,
  output logic         oe_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign out_o[i] = pass_i & vld_i & val_i[i];
  end

  assign oe_o = drive_i;
endmodule

// File: rtl/lps_reset_ctrl.sv
module lps_reset_ctrl
  import lps_rc_pkg::*;
#(
  parameter int CTL_W         = 2,
  parameter int DATA_W        = 8,
  parameter int LPS_RESET_CYC = 32,
  parameter int RESTORE_CYC   = 64,
  parameter int INIT_CYC      = 8,
  parameter int WIND_CYC      = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lps_i,
  input  logic              iso_i,
  input  logic [CTL_W-1:0]  ctl_val_i,
  input  logic              ctl_vld_i,
  input  logic [DATA_W-1:0] data_val_i,
  input  logic              data_vld_i,
  output logic [CTL_W-1:0]  ctl_o,
  output logic              ctl_oe_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              if_reset_o,
  output logic              restore_viol_o
);
  logic      lps_s;
  logic      timeout;
  rc_state_e st_q;
  logic      restore_met;
  logic      drive, pass;

  lps_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lps_i),
    .q_o   (lps_s)
  );

  lps_inact_cnt #(.LIMIT(LPS_RESET_CYC)) u_inact (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lps_s_i  (lps_s),
    .timeout_o(timeout)
  );

  lps_rc_fsm #(
    .RESTORE_CYC(RESTORE_CYC),
    .INIT_CYC   (INIT_CYC),
    .WIND_CYC   (WIND_CYC)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lps_s_i      (lps_s),
    .iso_i        (iso_i),
    .timeout_i    (timeout),
    .st_o         (st_q),
    .restore_met_o(restore_met),
    .drive_o      (drive),
    .pass_o       (pass),
    .if_reset_o   (if_reset_o),
    .viol_o       (restore_viol_o)
  );

  lps_lane_drv #(.W(CTL_W)) u_ctl_drv (
    .drive_i(drive),
    .pass_i (pass),
    .vld_i  (ctl_vld_i),
    .val_i  (ctl_val_i),
    .out_o  (ctl_o),
    .oe_o   (ctl_oe_o)
  );

  lps_lane_drv #(.W(DATA_W)) u_data_drv (
    .drive_i(drive),
    .pass_i (pass),
    .vld_i  (data_vld_i),
    .val_i  (data_val_i),
    .out_o  (data_o),
    .oe_o   (data_oe_o)
  );
endmodule

// File: rtl/lps_rc_chk.sv
module lps_rc_chk
  import lps_rc_pkg::*;
#(
  parameter int CTL_W  = 2,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              iso_i,
  input logic [CTL_W-1:0]  ctl_val_i,
  input logic              ctl_vld_i,
  input logic [CTL_W-1:0]  ctl_o,
  input logic              ctl_oe_o,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              if_reset_o,
  input logic              restore_viol_o,
  input rc_state_e         st_i,
  input logic              restore_met_i
);
  assert_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_NORMAL && ctl_vld_i) |-> (ctl_oe_o && data_oe_o && ctl_o == ctl_val_i));

  assert_zero_before_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(data_oe_o) |-> ($past(data_o) == '0 && $past(ctl_o) == '0));

  assert_reset_hiz_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_reset_o |-> (!ctl_oe_o && !data_oe_o && ctl_o == '0 && data_o == '0));

  assert_early_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_RESET && !restore_met_i) |=> (st_i != ST_INIT));

  assert_init_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_INIT) |-> (ctl_oe_o && data_oe_o && ctl_o == '0 && data_o == '0 && !if_reset_o));

  assert_iso_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_NORMAL && iso_i) |=> (st_i == ST_NORMAL));

  assert_viol_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_viol_o |=> restore_viol_o);
endmodule

bind lps_reset_ctrl lps_rc_chk #(.CTL_W(CTL_W), .DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .iso_i         (iso_i),
  .ctl_val_i     (ctl_val_i),
  .ctl_vld_i     (ctl_vld_i),
  .ctl_o         (ctl_o),
  .ctl_oe_o      (ctl_oe_o),
  .data_o        (data_o),
  .data_oe_o     (data_oe_o),
  .if_reset_o    (if_reset_o),
  .restore_viol_o(restore_viol_o),
  .st_i          (st_q),
  .restore_met_i (restore_met)
);

// File: tb/tb_lps_reset_ctrl.sv
module tb_lps_reset_ctrl;
  localparam int N  = 6;
  localparam int RC = 10;
  localparam int IC = 4;
  localparam int WC = 1;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lps_i = 1'b0;
  logic       iso_i = 1'b0;
  logic [1:0] ctl_val_i = 2'b11;
  logic       ctl_vld_i = 1'b1;
  logic [7:0] data_val_i = 8'hA5;
  logic       data_vld_i = 1'b1;
  logic [1:0] ctl_o;
  logic       ctl_oe_o;
  logic [7:0] data_o;
  logic       data_oe_o;
  logic       if_reset_o;
  logic       restore_viol_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  lps_reset_ctrl #(
    .LPS_RESET_CYC(N), .RESTORE_CYC(RC), .INIT_CYC(IC), .WIND_CYC(WC)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .lps_i(lps_i), .iso_i(iso_i),
    .ctl_val_i(ctl_val_i), .ctl_vld_i(ctl_vld_i),
    .data_val_i(data_val_i), .data_vld_i(data_vld_i),
    .ctl_o(ctl_o), .ctl_oe_o(ctl_oe_o), .data_o(data_o), .data_oe_o(data_oe_o),
    .if_reset_o(if_reset_o), .restore_viol_o(restore_viol_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic chk_pass(input string req);
    logic [1:0] ec;
    logic [7:0] ed;
    ec = ctl_vld_i ? ctl_val_i : 2'b00;
    ed = data_vld_i ? data_val_i : 8'h00;
    chk(req, {29'd0, ctl_oe_o, data_oe_o, if_reset_o}, 32'b110);
    chk(req, {22'd0, ctl_o, data_o}, {22'd0, ec, ed});
  endtask

  task automatic chk_zero(input string req);
    chk(req, {19'd0, ctl_oe_o, data_oe_o, if_reset_o, ctl_o, data_o}, {19'd0, 3'b110, 10'd0});
  endtask

  task automatic chk_rst(input string req);
    chk(req, {19'd0, ctl_oe_o, data_oe_o, if_reset_o, ctl_o, data_o}, {19'd0, 3'b001, 10'd0});
  endtask

  // R7: raise power-status with restore interval met
  task automatic bring_up();
    lps_i = 1'b1;
    for (int m = 1; m <= IC + 4; m++) begin
      cyc();
      if (m <= 2)           chk_rst("R7 hold");
      else if (m <= IC + 2) chk_zero("R7 init");
      else                  chk_pass("R7 normal");
    end
  endtask

  // R4/R5: held dropout, returns after reset entry (m = N+WC+2)
  task automatic held_drop(input int extra);
    lps_i = 1'b0;
    for (int m = 1; m <= N + WC + 2 + extra; m++) begin
      cyc();
      if (m <= N + 1)           chk_pass("R4 before timeout");
      else if (m <= N + WC + 1) chk_zero("R4 wind");
      else                      chk_rst("R5 reset");
    end
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    #1;
    chk_rst("R1");
    chk("R1 viol", {31'd0, restore_viol_o}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk_rst("R1 post");

    bring_up();
    chk("R7 viol", {31'd0, restore_viol_o}, 32'd0);

    // R2 sweep of values and valid combinations
    for (int v = 0; v < 512; v++) begin
      data_val_i = v[7:0];
      ctl_val_i  = v[1:0];
      ctl_vld_i  = v[8] ^ v[0];
      data_vld_i = v[8];
      #1;
      chk_pass("R2");
      @(negedge clk);
    end
    ctl_val_i = 2'b11; data_val_i = 8'hA5; ctl_vld_i = 1'b1; data_vld_i = 1'b1;

    // R3 short dropouts up to one below the threshold
    for (int l = 1; l < N; l++) begin
      lps_i = 1'b0;
      for (int m = 1; m <= N + WC + 6; m++) begin
        cyc();
        if (m == l) lps_i = 1'b1;
        chk_pass("R3");
      end
    end

    // R4/R5 held dropout, then late restore (R7)
    held_drop(RC + 3);
    chk("R5 viol", {31'd0, restore_viol_o}, 32'd0);
    bring_up();
    chk("R7 late viol", {31'd0, restore_viol_o}, 32'd0);

    // R6 early re-assertion
    held_drop(0);
    lps_i = 1'b1;
    for (int j = 1; j <= RC + IC + 3; j++) begin
      cyc();
      if (j <= RC)           chk_rst("R6 ignored");
      else if (j <= RC + IC) chk_zero("R6 init after interval");
      else                   chk_pass("R6 normal");
      chk("R6 viol", {31'd0, restore_viol_o}, (j >= 3) ? 32'd1 : 32'd0);
    end
    chk("R9 sticky", {31'd0, restore_viol_o}, 32'd1);

    // R8 isolated mode ignores a long dropout
    iso_i = 1'b1;
    lps_i = 1'b0;
    for (int m = 1; m <= 3 * N; m++) begin
      cyc();
      chk_pass("R8");
    end
    lps_i = 1'b1;
    repeat (4) cyc();
    iso_i = 1'b0;
    for (int m = 1; m <= 2 * N; m++) begin
      cyc();
      chk_pass("R8 back");
    end
    chk("R9 still", {31'd0, restore_viol_o}, 32'd1);

    // R9 cleared only by reset
    rst_ni = 1'b0;
    #1;
    chk("R9 clear", {31'd0, restore_viol_o}, 32'd0);
    chk_rst("R1 again");

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule